// File: doc/BRIEF.md
# Packet Radio Link Controller

This block is the top-level sequencer for a packet radio front end. It brings the radio up after reset, accepts one 32-bit word per transfer through a ready/start handshake, and turns each word into a load and a send operation. The load and send go to a command sequencer, which handles byte framing and the serial link to the radio. The controller watches four single-bit status lines from the radio: receive data present, receive threshold reached, channel clear, and frame in flight.

Before any send, the controller requires the channel to be clear. When the channel is busy, it backs off for a pseudo-random number of symbol periods, then looks at the channel again. During the backoff it keeps draining received data and flushes the receive buffer if it has overflowed. After the receiver is switched on, and again after each frame has left the air, it waits twelve symbol periods before it reports ready. The radio channel can be changed while the block is running, with no reset.

States and transitions. After reset the sequence is INIT → TUNE → RXON → SETTLE → READY, and each of the first three steps advances when its command is acknowledged. From READY:
- start goes to LOAD;
- otherwise a channel request goes to TUNE;
- otherwise an overflow goes to FLUSH;
- otherwise pending receive data goes to RX.

The transmit path is:
- LOAD goes to CCA on acknowledge.
- CCA goes to FLUSH on overflow, to SEND when the channel is clear, and otherwise to BACKOFF.
- BACKOFF goes to FLUSH on overflow, to RX when data is pending, and to CCA when its timer expires.
- RX and FLUSH return to BACKOFF while a word is pending, and to READY when none is.
- SEND goes to TXWAIT on acknowledge.
- TXWAIT goes to SETTLE once the frame-in-flight line has risen and then fallen.

Top module: `radio_link_ctrl`

## Requirements
- R1: After reset, the controller issues exactly three commands in this order: INIT, TUNE carrying the default channel (5), and RXON. Each command holds its opcode until `cmd_done` is seen. The opcodes are INIT=0, TUNE=1, RXON=2, LOAD=3, SEND=4, READ=5 and FLUSH=6.
- R2: `ready` first rises between 12 and 12+4/CYC_PER_SYM symbol periods (12·CYC_PER_SYM to 12·CYC_PER_SYM+4 clock cycles) after the RXON acknowledge.
- R3: When `start` is high while `ready` is high, `ready` drops on the next cycle and a LOAD command is issued whose `cmd_data` equals the accepted `tx_word`.
- R4: A SEND command is issued only when `chan_clear` was high at the sampling edge. No SEND appears while `chan_clear` stays low.
- R5: When the channel is busy, the controller waits 1 to 32 symbol periods and then re-checks it. SEND therefore follows within 32·CYC_PER_SYM+20 cycles of `chan_clear` rising.
- R6: Pending receive data (`rxf_nonempty` high) is read with READ commands, both in READY and during a backoff. Each READ acknowledge produces a one-cycle `rx_valid` on the next cycle, with `rx_data` equal to `rsp_data`.
- R7: An overflow (`rxf_thresh` high while `rxf_nonempty` is low) causes a FLUSH command, both in READY and during a backoff. No SEND is issued before that flush.
- R8: `ready` stays low from an accepted start until the frame-in-flight line has risen and fallen. It then rises 12·CYC_PER_SYM to 12·CYC_PER_SYM+4 cycles after that fall.
- R9: A channel request in READY issues TUNE with the new channel, then RXON, then the 12-symbol settle. A request made outside READY has no effect: no TUNE is issued and `cmd_chan` keeps its value.
- R10: A `start` pulse while `ready` is low is ignored. Exactly one LOAD is issued per accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send `tx_word` |
| tx_word | input | WORD_W | Word to transmit |
| ready | output | 1 | Controller idle and able to take a word |
| chan_req | input | 1 | Request a channel change |
| chan_sel | input | CHAN_W | Requested channel |
| rxf_nonempty | input | 1 | Radio holds received data |
| rxf_thresh | input | 1 | Receive byte threshold reached |
| chan_clear | input | 1 | Radio reports a clear channel |
| frame_active | input | 1 | Frame is on the air |
| cmd_valid | output | 1 | Command pending to the sequencer |
| cmd_op | output | 3 | Command opcode (see R1) |
| cmd_data | output | WORD_W | Word for LOAD, zero otherwise |
| cmd_chan | output | CHAN_W | Current channel, used by TUNE |
| cmd_done | input | 1 | Sequencer acknowledge, one cycle |
| rsp_data | input | WORD_W | Word returned with a READ acknowledge |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | WORD_W | Received word |

## Verification
The hardest situation to reach is a busy channel that overlaps with receive activity. While the random backoff timer is running, the controller must leave BACKOFF for RX or FLUSH and then come back, with no send slipping through. The bench reaches it by queuing received words in its sequencer model at the same edge as the start, and by holding `chan_clear` low for a window of its own choosing after the load is acknowledged. In a separate pass it raises the overflow condition in the middle of that window. It then checks that every queued word was read out, or the flush was issued, before it releases the channel and times the send.

// File: rtl/radio_ctrl_pkg.sv
package radio_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_INIT,
        ST_TUNE,
        ST_RXON,
        ST_SETTLE,
        ST_READY,
        ST_LOAD,
        ST_CCA,
        ST_BACKOFF,
        ST_RX,
        ST_FLUSH,
        ST_SEND,
        ST_TXWAIT
    } ctrl_state_e;

    typedef enum logic [2:0] {
        OP_INIT  = 3'd0,
        OP_TUNE  = 3'd1,
        OP_RXON  = 3'd2,
        OP_LOAD  = 3'd3,
        OP_SEND  = 3'd4,
        OP_READ  = 3'd5,
        OP_FLUSH = 3'd6
    } radio_op_e;

endpackage

// File: rtl/sym_wait_timer.sv
// Down-counter of symbol periods with its own cycle prescaler.
// The prescaler restarts on every load, so a wait of N symbols is exact.
module sym_wait_timer #(
    parameter int CYC_PER_SYM = 800,
    parameter int CNT_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    localparam int PRE_W = (CYC_PER_SYM > 1) ? $clog2(CYC_PER_SYM) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_SYM - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/backoff_prng.sv
// Free-running 16-bit Galois LFSR; the low OUT_W bits seed the backoff.
module backoff_prng #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          OUT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] value
);
    localparam logic [15:0] TAPS = 16'hB400;

    logic [15:0] lfsr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0000);
        end
    end

    assign value = lfsr_q[OUT_W-1:0];
endmodule

// File: rtl/radio_link_ctrl.sv
module radio_link_ctrl
    import radio_ctrl_pkg::*;
#(
    parameter int          WORD_W      = 32,
    parameter int          CHAN_W      = 4,
    parameter int          DEF_CHAN    = 5,
    parameter int          CYC_PER_SYM = 800,
    parameter int          SETTLE_SYM  = 12,
    parameter int          BACKOFF_W   = 5,
    parameter logic [15:0] PRNG_SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    output logic              ready,
    input  logic              chan_req,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              rxf_nonempty,
    input  logic              rxf_thresh,
    input  logic              chan_clear,
    input  logic              frame_active,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [WORD_W-1:0] cmd_data,
    output logic [CHAN_W-1:0] cmd_chan,
    input  logic              cmd_done,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_data
);
    localparam int SETTLE_W = $clog2(SETTLE_SYM + 1);
    localparam int CNT_W    = (SETTLE_W > BACKOFF_W + 1) ? SETTLE_W : BACKOFF_W + 1;

    ctrl_state_e state_q, state_d;
    radio_op_e   op_c;

    logic [WORD_W-1:0]    txbuf_q;
    logic [CHAN_W-1:0]    chan_q;
    logic                 tx_pend_q;
    logic                 frame_seen_q;
    logic                 overflow;
    logic                 settle_load, settle_run, settle_zero;
    logic                 bo_load, bo_run, bo_zero;
    logic [BACKOFF_W-1:0] bo_rand;
    logic [CNT_W-1:0]     bo_val;

    assign overflow = rxf_thresh & ~rxf_nonempty;

    // settle wait after receiver start and after each frame
    sym_wait_timer #(.CYC_PER_SYM(CYC_PER_SYM), .CNT_W(CNT_W)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .load_val(CNT_W'(SETTLE_SYM)),
        .run     (settle_run),
        .zero    (settle_zero)
    );

    // random backoff while the channel is busy
    sym_wait_timer #(.CYC_PER_SYM(CYC_PER_SYM), .CNT_W(CNT_W)) u_backoff (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bo_load),
        .load_val(bo_val),
        .run     (bo_run),
        .zero    (bo_zero)
    );

    backoff_prng #(.SEED(PRNG_SEED), .OUT_W(BACKOFF_W)) u_prng (
        .clk  (clk),
        .rst_n(rst_n),
        .value(bo_rand)
    );

    assign bo_val = CNT_W'(bo_rand) + CNT_W'(1);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_INIT:   if (cmd_done) state_d = ST_TUNE;
            ST_TUNE:   if (cmd_done) state_d = ST_RXON;
            ST_RXON:   if (cmd_done) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_zero) state_d = ST_READY;
            ST_READY: begin
                if (start)             state_d = ST_LOAD;
                else if (chan_req)     state_d = ST_TUNE;
                else if (overflow)     state_d = ST_FLUSH;
                else if (rxf_nonempty) state_d = ST_RX;
            end
            ST_LOAD:   if (cmd_done) state_d = ST_CCA;
            ST_CCA: begin
                if (overflow)        state_d = ST_FLUSH;
                else if (chan_clear) state_d = ST_SEND;
                else                 state_d = ST_BACKOFF;
            end
            ST_BACKOFF: begin
                if (overflow)          state_d = ST_FLUSH;
                else if (rxf_nonempty) state_d = ST_RX;
                else if (bo_zero)      state_d = ST_CCA;
            end
            ST_RX, ST_FLUSH: begin
                if (cmd_done) state_d = tx_pend_q ? ST_BACKOFF : ST_READY;
            end
            ST_SEND:   if (cmd_done) state_d = ST_TXWAIT;
            ST_TXWAIT: if (frame_seen_q && !frame_active) state_d = ST_SETTLE;
            default:   state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INIT;
        else        state_q <= state_d;
    end

    // held data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txbuf_q      <= '0;
            chan_q       <= CHAN_W'(DEF_CHAN);
            tx_pend_q    <= 1'b0;
            frame_seen_q <= 1'b0;
            rx_valid     <= 1'b0;
            rx_data      <= '0;
        end else begin
            if (state_q == ST_READY && start) begin
                txbuf_q   <= tx_word;
                tx_pend_q <= 1'b1;
            end else if (state_q == ST_READY && chan_req) begin
                chan_q <= chan_sel;
            end
            if (state_q == ST_SEND && cmd_done) tx_pend_q <= 1'b0;

            if (state_q != ST_TXWAIT) frame_seen_q <= 1'b0;
            else if (frame_active)    frame_seen_q <= 1'b1;

            rx_valid <= (state_q == ST_RX) && cmd_done;
            if ((state_q == ST_RX) && cmd_done) rx_data <= rsp_data;
        end
    end

    // outputs
    always_comb begin
        cmd_valid   = 1'b0;
        op_c        = OP_INIT;
        cmd_data    = '0;
        ready       = 1'b0;
        settle_load = (state_d == ST_SETTLE) && (state_q != ST_SETTLE);
        settle_run  = (state_q == ST_SETTLE);
        bo_load     = (state_q == ST_CCA) && (state_d == ST_BACKOFF);
        bo_run      = tx_pend_q &&
                      ((state_q == ST_BACKOFF) || (state_q == ST_RX) || (state_q == ST_FLUSH));
        unique case (state_q)
            ST_INIT:  begin cmd_valid = 1'b1; op_c = OP_INIT;  end
            ST_TUNE:  begin cmd_valid = 1'b1; op_c = OP_TUNE;  end
            ST_RXON:  begin cmd_valid = 1'b1; op_c = OP_RXON;  end
            ST_LOAD:  begin cmd_valid = 1'b1; op_c = OP_LOAD; cmd_data = txbuf_q; end
            ST_RX:    begin cmd_valid = 1'b1; op_c = OP_READ;  end
            ST_FLUSH: begin cmd_valid = 1'b1; op_c = OP_FLUSH; end
            ST_SEND:  begin cmd_valid = 1'b1; op_c = OP_SEND;  end
            ST_READY: ready = 1'b1;
            default:  ;
        endcase
    end

    assign cmd_op   = op_c;
    assign cmd_chan = chan_q;
endmodule

// File: rtl/radio_link_ctrl_chk.sv
module radio_link_ctrl_chk
    import radio_ctrl_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [WORD_W-1:0] tx_word,
    input logic              ready,
    input logic              chan_req,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              chan_clear,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic [WORD_W-1:0] cmd_data,
    input logic [CHAN_W-1:0] cmd_chan,
    input logic              cmd_done,
    input logic              rx_valid
);
    // R1
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op)));

    // R3
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (!ready && cmd_valid && cmd_op == OP_LOAD && cmd_data == $past(tx_word)));

    // R4
    send_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_SEND && !($past(cmd_valid) && $past(cmd_op) == OP_SEND))
        |-> $past(chan_clear));

    // R6
    rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(cmd_done) && $past(cmd_op) == OP_READ));

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !ready);

    // R9
    chan_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_chan) |-> ($past(ready) && $past(chan_req) && cmd_chan == $past(chan_sel)));
endmodule

bind radio_link_ctrl radio_link_ctrl_chk #(.WORD_W(WORD_W), .CHAN_W(CHAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_word   (tx_word),
    .ready     (ready),
    .chan_req  (chan_req),
    .chan_sel  (chan_sel),
    .chan_clear(chan_clear),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .cmd_chan  (cmd_chan),
    .cmd_done  (cmd_done),
    .rx_valid  (rx_valid)
);

// File: tb/radio_link_ctrl_tb.sv
module radio_link_ctrl_tb;
    localparam int CPS = 8;
    localparam int SYM = 12 * CPS;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic        ready;
    logic        chan_req = 1'b0;
    logic [3:0]  chan_sel = '0;
    logic        rxf_nonempty;
    logic        rxf_thresh;
    logic        chan_clear = 1'b1;
    logic        frame_active = 1'b0;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [31:0] cmd_data;
    logic [3:0]  cmd_chan;
    logic        cmd_done = 1'b0;
    logic [31:0] rsp_data = '0;
    logic        rx_valid;
    logic [31:0] rx_data;

    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;
    int          cnt_op[8];
    logic [2:0]  op_log[0:63];
    int          n_log = 0;
    logic [31:0] last_load;
    logic [3:0]  last_chan;
    int          t_rxon = 0;
    int          t_fall = 0;
    logic [31:0] rxq[0:63];
    int          wr = 0;
    int          rd = 0;
    int          rx_seen = 0;
    logic        ovf = 1'b0;
    logic        sfd_go = 1'b0;
    bit          done_flag = 1'b0;

    assign rxf_nonempty = (wr != rd);
    assign rxf_thresh   = ovf;

    radio_link_ctrl #(.CYC_PER_SYM(CPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word), .ready(ready),
        .chan_req(chan_req), .chan_sel(chan_sel), .rxf_nonempty(rxf_nonempty),
        .rxf_thresh(rxf_thresh), .chan_clear(chan_clear), .frame_active(frame_active),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_chan(cmd_chan),
        .cmd_done(cmd_done), .rsp_data(rsp_data), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // sequencer model: acknowledges each command LAT cycles after it appears
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            if (cmd_done) begin
                cmd_done = 1'b0;
                lat = 0;
            end else if (cmd_valid && rst_n) begin
                if (lat < LAT) lat++;
                else begin
                    cmd_done = 1'b1;
                    cnt_op[cmd_op]++;
                    if (n_log < 64) op_log[n_log] = cmd_op;
                    n_log++;
                    case (cmd_op)
                        3'd1: last_chan = cmd_chan;
                        3'd2: t_rxon = cyc;
                        3'd3: last_load = cmd_data;
                        3'd4: begin
                            chk(chan_clear == 1'b1, "R4", "send with busy channel", chan_clear, 1);
                            chk(ready == 1'b0, "R8", "ready at send", ready, 0);
                            sfd_go = 1'b1;
                        end
                        3'd5: begin rsp_data = rxq[rd]; rd++; end
                        3'd6: ovf = 1'b0;
                        default: ;
                    endcase
                end
            end
        end
    end

    // frame-in-flight model
    initial begin
        forever begin
            @(negedge clk);
            if (sfd_go) begin
                sfd_go = 1'b0;
                repeat (3) @(negedge clk);
                frame_active = 1'b1;
                repeat (10) @(negedge clk);
                frame_active = 1'b0;
                t_fall = cyc;
            end
        end
    end

    // received word monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid) begin
                chk(rx_data == rxq[rx_seen], "R6", "rx_data", rx_data, rxq[rx_seen]);
                rx_seen++;
            end
        end
    end

    task automatic wait_cnt(input int op, input int target, input int limit, input string req);
        int k = 0;
        while (cnt_op[op] < target && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk(cnt_op[op] >= target, req, "command count", cnt_op[op], target);
    endtask

    task automatic wait_ready(input int limit, input string req);
        int k = 0;
        while (!ready && k < limit) begin
            @(negedge clk);
            k++;
        end
        chk(ready == 1'b1, req, "ready reached", ready, 1);
    endtask

    task automatic do_tx(input logic [31:0] w, input int low_cyc, input int n_rx);
        int s0;
        int l0;
        int t0;
        wait_ready(2000, "R8");
        s0 = cnt_op[4];
        l0 = cnt_op[3];
        chan_clear = (low_cyc == 0);
        for (int i = 0; i < n_rx; i++) begin
            rxq[wr] = $urandom;
            wr++;
        end
        tx_word = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R3", "ready after start", ready, 0);
        // R10: a start while busy must be ignored
        tx_word = ~w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cnt(3, l0 + 1, 50, "R3");
        chk(last_load == w, "R3", "load data", last_load, w);
        if (low_cyc > 0) begin
            repeat (low_cyc) @(negedge clk);
            chk(cnt_op[4] == s0, "R4", "sends while busy", cnt_op[4], s0);
            if (n_rx > 0) chk(rd == wr, "R6", "reads during backoff", rd, wr);
            chan_clear = 1'b1;
            t0 = cyc;
            wait_cnt(4, s0 + 1, 400, "R5");
            chk((cyc - t0) <= 32 * CPS + 20, "R5", "send delay after clear", cyc - t0, 32 * CPS + 20);
        end else begin
            wait_cnt(4, s0 + 1, 100, "R4");
        end
        wait_ready(2000, "R8");
        chk((cyc - t_fall) >= SYM && (cyc - t_fall) <= SYM + 4, "R8",
            "ready after frame end", cyc - t_fall, SYM);
        chk(cnt_op[3] == l0 + 1, "R10", "loads per word", cnt_op[3], l0 + 1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) cnt_op[i] = 0;
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            report();
        end
    end

    initial begin
        int tn;
        int f0;
        int s0;
        int l0;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
        chk(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;

        // R1, R2: bring-up
        wait_cnt(2, 1, 100, "R1");
        wait_ready(500, "R2");
        chk((cyc - t_rxon) >= SYM && (cyc - t_rxon) <= SYM + 4, "R2",
            "settle after rxon", cyc - t_rxon, SYM);
        chk(op_log[0] == 3'd0, "R1", "first op", op_log[0], 0);
        chk(op_log[1] == 3'd1, "R1", "second op", op_log[1], 1);
        chk(op_log[2] == 3'd2, "R1", "third op", op_log[2], 2);
        chk(last_chan == 4'd5, "R1", "default channel", last_chan, 5);
        chk(n_log == 3, "R1", "commands before ready", n_log, 3);

        // clear channel, then busy channel with receive traffic
        do_tx(32'hA5A5_0001, 0, 0);
        do_tx(32'h1234_5678, 120, 3);

        // R6: read from ready
        wait_ready(500, "R6");
        rxq[wr] = 32'hCAFE_F00D;
        wr++;
        wait_cnt(5, cnt_op[5] + 1, 50, "R6");
        repeat (3) @(negedge clk);
        chk(rx_seen == wr, "R6", "words delivered", rx_seen, wr);

        // R9: channel change in ready
        wait_ready(500, "R9");
        tn = cnt_op[1];
        chan_sel = 4'd11;
        chan_req = 1'b1;
        @(negedge clk);
        chan_req = 1'b0;
        wait_cnt(1, tn + 1, 50, "R9");
        chk(last_chan == 4'd11, "R9", "tuned channel", last_chan, 11);
        wait_cnt(2, 2, 50, "R9");
        wait_ready(500, "R9");
        chk((cyc - t_rxon) >= SYM && (cyc - t_rxon) <= SYM + 4, "R9",
            "settle after retune", cyc - t_rxon, SYM);

        // R9: request outside ready is ignored
        tn = cnt_op[1];
        fork
            do_tx(32'h0BAD_BEEF, 60, 0);
            begin
                repeat (4) @(negedge clk);
                chan_sel = 4'd3;
                chan_req = 1'b1;
                repeat (2) @(negedge clk);
                chan_req = 1'b0;
            end
        join
        chk(cnt_op[1] == tn, "R9", "tunes while busy", cnt_op[1], tn);
        chk(cmd_chan == 4'd11, "R9", "channel kept", cmd_chan, 11);

        // R7: overflow in ready
        wait_ready(500, "R7");
        f0 = cnt_op[6];
        ovf = 1'b1;
        wait_cnt(6, f0 + 1, 50, "R7");
        wait_ready(20, "R7");

        // R7: overflow during backoff
        s0 = cnt_op[4];
        l0 = cnt_op[3];
        f0 = cnt_op[6];
        chan_clear = 1'b0;
        tx_word = 32'h7777_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cnt(3, l0 + 1, 50, "R7");
        repeat (20) @(negedge clk);
        ovf = 1'b1;
        wait_cnt(6, f0 + 1, 50, "R7");
        chk(cnt_op[4] == s0, "R7", "send before flush", cnt_op[4], s0);
        chan_clear = 1'b1;
        wait_cnt(4, s0 + 1, 400, "R5");
        wait_ready(2000, "R8");

        // constrained random transfers
        for (int it = 0; it < 6; it++) begin
            int low;
            int nrx;
            low = ($urandom % 3 == 0) ? 0 : 40 + ($urandom % 300);
            nrx = (low > 0) ? ($urandom % 3) : 0;
            do_tx($urandom, low, nrx);
        end
        repeat (20) @(negedge clk);
        chk(rx_seen == wr, "R6", "all words delivered", rx_seen, wr);

        done_flag = 1'b1;
        report();
    end
endmodule